// File: doc/BRIEF.md
# Idle-Gap Delimited Packet Validator

This block sits behind a UART receiver on a half-duplex multi-drop serial link. The link has no framing characters, so packets are separated only by silence on the line. A retriggerable idle timer is restarted by every received character. From its count the block decides where a packet starts, whether the packet stayed continuous, and when it has ended. Every packet has a fixed length. Its last byte is a checksum, and each byte arrives with a line-error flag (parity or framing) from the UART.

A packet counts only if three conditions on the line hold. A long quiet period must come before it. No pause longer than a few character times may appear between its bytes. A short quiet period must follow it. When a packet passes every check, the block does two things on the same clock edge. It emits a one-cycle respond strobe, so the local transmitter can start its reply inside the turnaround window. It also copies the payload into a holding buffer that can be read by index.

A packet that fails any check is discarded in full, and the block waits for the next long quiet period before it looks for a new packet. Because of this, a master that never leaves the line quiet long enough can never cause a response. All thresholds are parameters counted in system clock cycles. The defaults are set for a 50 MHz clock: 8 ms before a packet, 0.5 ms after it, and about 44 µs between bytes.

Top module: `gap_packet_validator`

## Requirements
- R1: After reset, resp_go is 0 and rd_byte reads 0 at every index. Reset counts as bus activity, so the first packet needs LEAD_GAP_CYC idle cycles after reset is released.
- R2: A packet starts only at a byte that is preceded by at least LEAD_GAP_CYC idle cycles, that is, cycles with rx_valid low. If fewer idle cycles come before it, the byte is ignored and no packet starts.
- R3: Between consecutive bytes of a packet, up to INTRA_GAP_CYC idle cycles are allowed. One more idle cycle discards the packet.
- R4: A packet must hold exactly PKT_LEN bytes. A packet that ends early is discarded. A packet with an extra byte before its trailing gap completes is also discarded.
- R5: The last byte (index PKT_LEN-1) must equal the modulo-256 sum of bytes 0 to PKT_LEN-2. Otherwise the packet is discarded.
- R6: If rx_err is high with any byte of the packet, the packet is discarded.
- R7: Let the last byte be sampled at edge E. resp_go is then high for exactly one cycle, from edge E+TRAIL_GAP_CYC to the next edge. Any byte sampled at edges E+1 to E+TRAIL_GAP_CYC cancels the response.
- R8: On acceptance, bytes 0 to PKT_LEN-2 become readable on rd_byte at rd_idx 0 to PKT_LEN-2. They are available from the edge at which resp_go rises. A discarded packet leaves the readable bytes unchanged, and an index of PKT_LEN-1 or above reads 0.
- R9: After a discarded packet, the next packet preceded by the long gap is accepted on its own merits. No byte of the discarded packet is ever combined with it.
- R10: If no run of LEAD_GAP_CYC idle cycles occurs, resp_go stays 0, even when the byte stream carries valid checksums.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: the UART delivered a character |
| rx_byte | input | 8 | Received character, valid with rx_valid |
| rx_err | input | 1 | Parity or framing error on this character, valid with rx_valid |
| rd_idx | input | IDX_W | Index of the held payload byte to read |
| resp_go | output | 1 | One-cycle strobe: a valid packet ended, start the reply |
| rd_byte | output | 8 | Held payload byte at rd_idx (combinational) |

## Verification
The hardest situations to reach from the ports are the exact edges of each timing threshold. These are a lead gap one cycle short of LEAD_GAP_CYC, an inner pause of INTRA_GAP_CYC versus INTRA_GAP_CYC+1 cycles, and a stray byte on the last cycle of the trailing window. Each frame starts with a marker byte, so the idle count before the packet is known exactly. The frame is then built with a swept lead gap, inner pause position and length, stray-byte timing, error position and checksum corruption, all on a small parameter set. A long stream of all-zero bytes with valid checksums, sent without a long gap, shows that a babbling master cannot cause a response.

// File: rtl/gpv_pkg.sv
// Shared types for the idle-gap packet validator.
package gpv_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_COLLECT = 2'd1,
        ST_TRAIL   = 2'd2
    } gpv_state_e;
endpackage

// File: rtl/gpv_gap_timer.sv
// Retriggerable idle timer.
// Counts the clock cycles since the last received character, saturating at
// the long-gap threshold, and decodes the three gap thresholds from it.
// Assumes INTRA_GAP_CYC < TRAIL_GAP_CYC <= LEAD_GAP_CYC and TRAIL_GAP_CYC >= 1.
module gpv_gap_timer #(
    parameter int LEAD_GAP_CYC  = 400000,
    parameter int TRAIL_GAP_CYC = 25000,
    parameter int INTRA_GAP_CYC = 2200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    output logic lead_ok,
    output logic intra_over,
    output logic trail_due
);
    localparam int CW = $clog2(LEAD_GAP_CYC + 1);
    localparam logic [CW-1:0] LEAD_C     = CW'(LEAD_GAP_CYC);
    localparam logic [CW-1:0] INTRA_C    = CW'(INTRA_GAP_CYC);
    localparam logic [CW-1:0] TRAIL_M1_C = CW'(TRAIL_GAP_CYC - 1);

    logic [CW-1:0] idle_cnt;

    // Restart on every character, otherwise count up to the long-gap limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_cnt <= '0;
        end else if (rx_valid) begin
            idle_cnt <= '0;
        end else if (idle_cnt != LEAD_C) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign lead_ok    = (idle_cnt >= LEAD_C);
    assign intra_over = (idle_cnt > INTRA_C);
    assign trail_due  = (idle_cnt == TRAIL_M1_C);
endmodule

// File: rtl/gpv_frame_ctl.sv
// Packet framing and acceptance control.
// Hunts for a byte after a long gap, collects PKT_LEN bytes while checking
// inner gaps, checksum and line errors, then waits out the trailing gap and
// raises commit/resp_go for a clean packet. Assumes PKT_LEN >= 2.
module gpv_frame_ctl
    import gpv_pkg::*;
#(
    parameter int PKT_LEN = 8,
    parameter int IDX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_err,
    input  logic             lead_ok,
    input  logic             intra_over,
    input  logic             trail_due,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             commit,
    output logic             resp_go
);
    localparam int LW = $clog2(PKT_LEN + 1);
    localparam logic [LW-1:0] LAST_C = LW'(PKT_LEN - 1);

    gpv_state_e    state;
    logic [LW-1:0] got_cnt;
    logic [7:0]    sum_acc;
    logic          bad_seen;
    logic          pkt_ok;
    logic          start_pkt;
    logic          take_byte;
    logic          last_byte;

    // Decode this cycle's framing events.
    always_comb begin
        start_pkt = (state == ST_HUNT) && rx_valid && lead_ok;
        take_byte = (state == ST_COLLECT) && !intra_over && rx_valid;
        last_byte = take_byte && (got_cnt == LAST_C);
        wr_en     = start_pkt || (take_byte && !last_byte);
        wr_idx    = start_pkt ? '0 : IDX_W'(got_cnt);
        commit    = (state == ST_TRAIL) && trail_due && !rx_valid && pkt_ok;
    end

    // Framing state machine with running checksum and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_HUNT;
            got_cnt  <= '0;
            sum_acc  <= '0;
            bad_seen <= 1'b0;
            pkt_ok   <= 1'b0;
        end else begin
            unique case (state)
                ST_HUNT: begin
                    if (start_pkt) begin
                        state    <= ST_COLLECT;
                        got_cnt  <= LW'(1);
                        sum_acc  <= rx_byte;
                        bad_seen <= rx_err;
                    end
                end
                ST_COLLECT: begin
                    if (intra_over) begin
                        state <= ST_HUNT;
                    end else if (last_byte) begin
                        state  <= ST_TRAIL;
                        pkt_ok <= !bad_seen && !rx_err && (sum_acc == rx_byte);
                    end else if (take_byte) begin
                        got_cnt  <= got_cnt + 1'b1;
                        sum_acc  <= sum_acc + rx_byte;
                        bad_seen <= bad_seen | rx_err;
                    end
                end
                ST_TRAIL: begin
                    if (rx_valid || trail_due) begin
                        state <= ST_HUNT;
                    end
                end
                default: state <= ST_HUNT;
            endcase
        end
    end

    // Registered one-cycle response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_go <= 1'b0;
        end else begin
            resp_go <= commit;
        end
    end
endmodule

// File: rtl/gpv_payload_store.sv
// Payload staging and holding buffer.
// Stage entries fill as payload bytes arrive; on commit the whole stage is
// copied into the held entries read by index. Assumes PAY_LEN >= 1.
module gpv_payload_store #(
    parameter int PAY_LEN = 7,
    parameter int IDX_W   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [7:0]           wr_byte,
    input  logic                 commit,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [7:0]           rd_byte,
    output logic [PAY_LEN*8-1:0] held_flat
);
    logic [7:0] stage_q [PAY_LEN];
    logic [7:0] held_q  [PAY_LEN];

    for (genvar g = 0; g < PAY_LEN; g++) begin : g_entry
        // Capture an incoming payload byte into its stage slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                stage_q[g] <= wr_byte;
            end
        end

        // Copy the stage slot to the held slot when a packet is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q[g] <= '0;
            end else if (commit) begin
                held_q[g] <= stage_q[g];
            end
        end

        assign held_flat[g*8 +: 8] = held_q[g];
    end

    // Indexed read of the held payload, zero outside the payload range.
    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < PAY_LEN; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_byte = held_q[i];
            end
        end
    end
endmodule

// File: rtl/gap_packet_validator.sv
// Idle-gap delimited packet validator (top).
// Takes UART character strobes, frames fixed-length packets by line silence,
// validates them and raises a one-cycle respond strobe while publishing the
// payload. Thresholds are in clock cycles; defaults assume a 50 MHz clock.
module gap_packet_validator #(
    parameter int PKT_LEN       = 8,
    parameter int LEAD_GAP_CYC  = 400000,
    parameter int TRAIL_GAP_CYC = 25000,
    parameter int INTRA_GAP_CYC = 2200,
    parameter int PAY_LEN       = PKT_LEN - 1,
    parameter int IDX_W         = (PAY_LEN > 1) ? $clog2(PAY_LEN) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    input  logic             rx_err,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             resp_go,
    output logic [7:0]       rd_byte
);
    logic                 lead_ok;
    logic                 intra_over;
    logic                 trail_due;
    logic                 wr_en;
    logic [IDX_W-1:0]     wr_idx;
    logic                 commit;
    logic [PAY_LEN*8-1:0] held_payload;

    gpv_gap_timer #(
        .LEAD_GAP_CYC (LEAD_GAP_CYC),
        .TRAIL_GAP_CYC(TRAIL_GAP_CYC),
        .INTRA_GAP_CYC(INTRA_GAP_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .lead_ok   (lead_ok),
        .intra_over(intra_over),
        .trail_due (trail_due)
    );

    gpv_frame_ctl #(
        .PKT_LEN(PKT_LEN),
        .IDX_W  (IDX_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .rx_err    (rx_err),
        .lead_ok   (lead_ok),
        .intra_over(intra_over),
        .trail_due (trail_due),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .commit    (commit),
        .resp_go   (resp_go)
    );

    gpv_payload_store #(
        .PAY_LEN(PAY_LEN),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_byte  (rx_byte),
        .commit   (commit),
        .rd_idx   (rd_idx),
        .rd_byte  (rd_byte),
        .held_flat(held_payload)
    );
endmodule

// File: rtl/gpv_checker.sv
// Assertion checker for gap_packet_validator, attached by bind.
// Keeps its own idle count and byte-run count from the port activity.
module gpv_checker #(
    parameter int PKT_LEN       = 8,
    parameter int LEAD_GAP_CYC  = 400000,
    parameter int TRAIL_GAP_CYC = 25000,
    parameter int PAY_LEN       = PKT_LEN - 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_valid,
    input logic                 rx_err,
    input logic                 resp_go,
    input logic [PAY_LEN*8-1:0] held_payload
);
    localparam int CW = $clog2(LEAD_GAP_CYC + 1);
    localparam int RW = $clog2(PKT_LEN + 2);
    localparam logic [CW-1:0] LEAD_C  = CW'(LEAD_GAP_CYC);
    localparam logic [CW-1:0] TRAIL_C = CW'(TRAIL_GAP_CYC);
    localparam logic [RW-1:0] LEN_C   = RW'(PKT_LEN);
    localparam logic [RW-1:0] SAT_C   = RW'(PKT_LEN + 1);

    logic [CW-1:0] quiet_cnt;
    logic [RW-1:0] run_cnt;
    logic          run_err;

    // Independent idle count since the last character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_cnt <= '0;
        end else if (rx_valid) begin
            quiet_cnt <= '0;
        end else if (quiet_cnt != LEAD_C) begin
            quiet_cnt <= quiet_cnt + 1'b1;
        end
    end

    // Bytes and errors since the last long gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= SAT_C;
            run_err <= 1'b0;
        end else if (rx_valid) begin
            if (quiet_cnt >= LEAD_C) begin
                run_cnt <= RW'(1);
                run_err <= rx_err;
            end else begin
                run_cnt <= (run_cnt == SAT_C) ? run_cnt : run_cnt + 1'b1;
                run_err <= run_err | rx_err;
            end
        end
    end

    AST_RESP_SINGLE:      assert property (@(posedge clk) disable iff (!rst_n) resp_go |=> !resp_go);                 // R7
    AST_RESP_TRAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n) resp_go |-> (quiet_cnt == TRAIL_C));  // R7
    AST_RESP_RUN_LEN:     assert property (@(posedge clk) disable iff (!rst_n) resp_go |-> (run_cnt == LEN_C));      // R4
    AST_RESP_CLEAN_LINE:  assert property (@(posedge clk) disable iff (!rst_n) resp_go |-> !run_err);                // R6
    AST_HELD_STABLE:      assert property (@(posedge clk) disable iff (!rst_n) !resp_go |-> $stable(held_payload));  // R8
endmodule

bind gap_packet_validator gpv_checker #(
    .PKT_LEN      (PKT_LEN),
    .LEAD_GAP_CYC (LEAD_GAP_CYC),
    .TRAIL_GAP_CYC(TRAIL_GAP_CYC),
    .PAY_LEN      (PAY_LEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_err      (rx_err),
    .resp_go     (resp_go),
    .held_payload(held_payload)
);

// File: tb/sim_gap_packet_validator.sv
// Bench for gap_packet_validator on a small configuration with swept gaps.
module sim_gap_packet_validator;
    localparam int PL  = 4;
    localparam int LG  = 12;
    localparam int TG  = 5;
    localparam int IG  = 2;
    localparam int PAY = PL - 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_err = 1'b0;
    logic [1:0] rd_idx = '0;
    logic       resp_go;
    logic [7:0] rd_byte;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [PAY];

    always #10 clk = ~clk;

    gap_packet_validator #(
        .PKT_LEN      (PL),
        .LEAD_GAP_CYC (LG),
        .TRAIL_GAP_CYC(TG),
        .INTRA_GAP_CYC(IG)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_valid(rx_valid),
        .rx_byte (rx_byte),
        .rx_err  (rx_err),
        .rd_idx  (rd_idx),
        .resp_go (resp_go),
        .rd_byte (rd_byte)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic e);
        rx_valid = 1'b1;
        rx_byte  = b;
        rx_err   = e;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_err   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_buffer(input string tag);
        for (int k = 0; k < PAY + 1; k++) begin
            rd_idx = 2'(k);
            #1;
            if (k < PAY) chk(rd_byte == model[k], tag, "held byte", rd_byte, model[k]);
            else         chk(rd_byte == 8'h00, tag, "out-of-range read", rd_byte, 0);
        end
    endtask

    // One framed attempt: marker byte, lead gap, packet, watched trailing window.
    task automatic run_frame(input bit mark, input int lead, input int nb,
                             input int gap_at, input int gap_len, input int err_at,
                             input logic [7:0] flip, input int trail_at,
                             input logic [7:0] seed, input string tag);
        logic [7:0] b [8];
        logic [7:0] s;
        int first;
        int cnt;
        bit exp_ok;
        s = '0;
        for (int i = 0; i < nb - 1; i++) begin
            b[i] = seed + 8'(i * 61) + 8'd7;
            s = s + b[i];
        end
        b[nb-1] = s ^ flip;
        exp_ok = (lead >= LG) && (nb == PL) && (gap_at < 1 || gap_len <= IG)
                 && (err_at < 0) && (flip == 8'h00) && !(trail_at >= 1 && trail_at <= TG);
        if (mark) send_byte(8'hA5, 1'b0);
        idle(lead);
        for (int i = 0; i < nb; i++) begin
            if (i == gap_at) idle(gap_len);
            send_byte(b[i], (i == err_at));
        end
        first = 0;
        cnt = 0;
        for (int i = 1; i <= TG + 3; i++) begin
            if (i == trail_at) begin
                rx_valid = 1'b1;
                rx_byte  = 8'h3C;
            end
            @(negedge clk);
            rx_valid = 1'b0;
            if (resp_go) begin
                if (cnt == 0) first = i;
                cnt++;
            end
        end
        if (exp_ok) begin
            chk(cnt == 1, tag, "response pulses", cnt, 1);
            chk(first == TG, tag, "response cycle after last byte", first, TG);
            for (int k = 0; k < PAY; k++) model[k] = b[k];
        end else begin
            chk(cnt == 0, tag, "response pulses on rejected packet", cnt, 0);
        end
        check_buffer(exp_ok ? "R8" : "R8 unchanged");
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", n_chk, -1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int zero_hits;
        for (int k = 0; k < PAY; k++) model[k] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(resp_go == 1'b0, "R1", "resp_go after reset", resp_go, 0);
        check_buffer("R1");
        // R1: fewer than LG idle cycles since reset
        run_frame(1'b0, LG - 1, PL, -1, 0, -1, 8'h00, -1, 8'h11, "R1");
        // R2: lead gap sweep around the threshold, each followed by a clean frame (R9)
        for (int g = LG - 3; g <= LG + 2; g++) begin
            run_frame(1'b1, g, PL, -1, 0, -1, 8'h00, -1, 8'(g * 13), "R2");
            run_frame(1'b1, LG, PL, -1, 0, -1, 8'h00, -1, 8'(g * 29 + 1), "R9");
        end
        // R3: inner pause at every position, lengths 0..IG+1
        for (int p = 1; p < PL; p++) begin
            for (int gl = 0; gl <= IG + 1; gl++) begin
                run_frame(1'b1, LG, PL, p, gl, -1, 8'h00, -1, 8'(p * 40 + gl), "R3");
            end
        end
        // R4: wrong lengths, each with its own valid checksum; next clean frame (R9)
        for (int n = 2; n <= PL + 1; n++) begin
            run_frame(1'b1, LG, n, -1, 0, -1, 8'h00, -1, 8'(n * 7 + 3), "R4");
            run_frame(1'b1, LG + 1, PL, -1, 0, -1, 8'h00, -1, 8'(n * 9 + 5), "R9");
        end
        // R5: corrupted checksum
        run_frame(1'b1, LG, PL, -1, 0, -1, 8'h01, -1, 8'h21, "R5");
        run_frame(1'b1, LG, PL, -1, 0, -1, 8'h80, -1, 8'h22, "R5");
        run_frame(1'b1, LG, PL, -1, 0, -1, 8'hFF, -1, 8'h23, "R5");
        // R6: line error on every position
        for (int e = 0; e < PL; e++) begin
            run_frame(1'b1, LG, PL, -1, 0, e, 8'h00, -1, 8'(e * 17 + 2), "R6");
        end
        // R7 / R4: stray byte at each point of the trailing window and beyond
        for (int t = 1; t <= TG + 2; t++) begin
            run_frame(1'b1, LG, PL, -1, 0, -1, 8'h00, t, 8'(t * 23 + 9), "R7");
        end
        run_frame(1'b1, LG, PL, -1, 0, -1, 8'h00, -1, 8'h5A, "R9");
        // R10: babbling master with short gaps, valid checksums each time
        for (int r = 0; r < 20; r++) begin
            run_frame(1'b1, LG - 1, PL, -1, 0, -1, 8'h00, -1, 8'(r * 31), "R10");
        end
        // R10: continuous all-zero stream after a long gap
        idle(LG + 2);
        zero_hits = 0;
        for (int i = 0; i < 200; i++) begin
            send_byte(8'h00, 1'b0);
            if (resp_go) zero_hits++;
            @(negedge clk);
            if (resp_go) zero_hits++;
        end
        for (int i = 0; i < TG + 3; i++) begin
            @(negedge clk);
            if (resp_go) zero_hits++;
        end
        chk(zero_hits == 0, "R10", "pulses during zero stream", zero_hits, 0);
        check_buffer("R10");
        // R9: recovery after the babble
        run_frame(1'b1, LG, PL, -1, 0, -1, 8'h00, -1, 8'hC3, "R9");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule